// File: doc/BRIEF.md
# Mode-Configurable Serial Character Transmitter

This block turns a stream of parallel characters into a single serial bit stream. It runs on the bit clock. An internal slot counter divides that clock into character slots of 10 or 12 bit times. In the bit cycle that ends each slot the block raises `charTick`. On the next rising edge it samples the character inputs and loads a new transmit word into a shift register. The shift register then sends that word out least-significant bit first.

Each slot carries one of three things. In encoded mode a data byte becomes two 5-bit 4B/5B symbols, and a command nibble becomes a special character. In pre-encoded mode a 10-bit or 12-bit word passes through unchanged. When no valid character is offered, the slot carries a fill pair, so the line never stalls. Strap inputs choose the mode. A stub stands in for the buffering FIFO: its reset and halt inputs matter only when the FIFO-bypass strap is high.

Top module: `txp_serial_tx`

## Requirements
- R1: The slot length is 12 bit cycles when `encBypass` is 1 and `byteSel` is 0, and 10 bit cycles otherwise. The length is chosen from the straps on the edge that loads the character. `charTick` is high for exactly one cycle per slot, in the last bit cycle of the slot. Inputs are sampled on the rising edge where `charTick` is high.
- R2: `rst` is a synchronous, active-high reset. While it is held, and in the cycle after it is released, `serOut` is 0 and `charTick` is 1.
- R3: After a load edge, `serOut` in the k-th following cycle (k = 1..length) equals bit k-1 of the loaded word.
- R4: In encoded mode (`encBypass` 0) with `txSpecial` 0, the word is {S(txData[7:4]), S(txData[3:0])}, with the low nibble in bits 4:0. The symbol map S, from nibble 0 to 15, is 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101, each read as a binary number.
- R5: In encoded mode with `txSpecial` 1, the word is {S(txCmd), 5'b00100} and `txData` has no effect.
- R6: When `txEn` is 0 on a load edge, the slot carries a fill pair. With `fillSel` 0 the pair is 10'b10001_11000 (the 11000 symbol in bits 4:0). With `fillSel` 1 it is 10'b01101_00111.
- R7: With `encBypass` 1 and `byteSel` 1, the word is `txData[9:0]` unchanged, and `txSpecial` has no effect.
- R8: With `encBypass` 1 and `byteSel` 0, the word is {txCmd[1:0], txData[9:0]}, sent over 12 bits.
- R9: With `fifoByp` 0, `fifoRst` and `fifoHalt` have no effect on the output.
- R10: With `fifoByp` 1, if `fifoRst` or `fifoHalt` is 1 on a load edge, the slot carries the fill pair instead of the offered character.
- R11: A fill pair sent in a 12-bit slot is zero-extended, so bits 11:10 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| txData | input | 10 | Character data bus |
| txCmd | input | 4 | Command nibble; its low bits extend the 12-bit pre-encoded word |
| txSpecial | input | 1 | 1 selects special-character encoding |
| txEn | input | 1 | Character valid |
| fifoByp | input | 1 | FIFO-bypass strap (0 = synchronous) |
| fifoRst | input | 1 | FIFO stub reset |
| fifoHalt | input | 1 | FIFO stub halt |
| encBypass | input | 1 | 1 = pre-encoded path |
| byteSel | input | 1 | Pre-encoded width: 1 = 10 bits, 0 = 12 bits |
| fillSel | input | 1 | Fill pair choice |
| serOut | output | 1 | Serial data, LSB first |
| charTick | output | 1 | Last bit of the slot; inputs are sampled on the next edge |

## Verification
The assertions assume that the straps and character inputs change only in cycles where `charTick` is high, so the values they read with `$past` are the ones that were actually loaded. The stimulus meets this assumption: it changes every input at the falling edge of a cycle in which it has seen `charTick` high, and holds it for the whole slot. It sweeps every data byte, every command nibble and every 10-bit pre-encoded value, and it crosses the FIFO straps with both fill choices.

// File: rtl/txp_pkg.sv
package txp_pkg;
  localparam int DATA_W     = 10;
  localparam int CMD_W      = 4;
  localparam int NIB_W      = 4;
  localparam int SYM_W      = 5;
  localparam int NIBBLES    = 2;
  localparam int CHAR_SHORT = NIBBLES * SYM_W;
  localparam int CHAR_LONG  = 12;
  localparam int EXT_W      = CHAR_LONG - DATA_W;
  localparam int CNT_W      = $clog2(CHAR_LONG);

  localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_L    = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_M    = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_MARK = 5'b00100;

  typedef struct packed {
    logic load;
    logic fill;
  } strobe_t;

  function automatic logic [SYM_W-1:0] dataSym(input logic [NIB_W-1:0] nib);
    logic [SYM_W-1:0] s;
    case (nib)
      4'h0: s = 5'b11110;  4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;  4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;  4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;  4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;  4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;  4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;  4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;  default: s = 5'b11101;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/txp_ctrl.sv
module txp_ctrl
  import txp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    txEn,
  input  logic    fifoByp,
  input  logic    fifoRst,
  input  logic    fifoHalt,
  input  logic    encBypass,
  input  logic    byteSel,
  output strobe_t strobe,
  output logic    charTick
);
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] nextLast;
  logic             fifoMask;

  // slot length for the character loaded on this edge
  assign nextLast = (encBypass && !byteSel) ? CNT_W'(CHAR_LONG - 1)
                                            : CNT_W'(CHAR_SHORT - 1);
  assign charTick = (bitCnt == lastIdx);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt  <= '0;
      lastIdx <= '0;
    end else if (charTick) begin
      bitCnt  <= '0;
      lastIdx <= nextLast;
    end else begin
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  // FIFO stub: reset/halt only count when the bypass strap is high
  assign fifoMask    = fifoByp && (fifoRst || fifoHalt);
  assign strobe.load = charTick;
  assign strobe.fill = !txEn || fifoMask;
endmodule

// File: rtl/txp_dpath.sv
module txp_dpath
  import txp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] txData,
  input  logic [CMD_W-1:0]  txCmd,
  input  logic              txSpecial,
  input  logic              encBypass,
  input  logic              byteSel,
  input  logic              fillSel,
  output logic              serOut
);
  logic [CHAR_SHORT-1:0] dataWord;
  logic [CHAR_SHORT-1:0] cmdWord;
  logic [CHAR_SHORT-1:0] fillWord;
  logic [CHAR_LONG-1:0]  nextWord;
  logic [CHAR_LONG-1:0]  shiftReg;

  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    assign dataWord[g*SYM_W +: SYM_W] = dataSym(txData[g*NIB_W +: NIB_W]);
  end

  assign cmdWord  = {dataSym(txCmd[NIB_W-1:0]), SYM_MARK};
  assign fillWord = fillSel ? {SYM_M, SYM_L} : {SYM_K, SYM_J};

  always_comb begin
    if (strobe.fill)
      nextWord = CHAR_LONG'(fillWord);
    else if (encBypass)
      nextWord = byteSel ? CHAR_LONG'(txData) : {txCmd[EXT_W-1:0], txData};
    else if (txSpecial)
      nextWord = CHAR_LONG'(cmdWord);
    else
      nextWord = CHAR_LONG'(dataWord);
  end

  always_ff @(posedge clk) begin
    if (rst)
      shiftReg <= '0;
    else if (strobe.load)
      shiftReg <= nextWord;
    else
      shiftReg <= shiftReg >> 1;
  end

  assign serOut = shiftReg[0];
endmodule

// File: rtl/txp_serial_tx.sv
module txp_serial_tx
  import txp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] txData,
  input  logic [CMD_W-1:0]  txCmd,
  input  logic              txSpecial,
  input  logic              txEn,
  input  logic              fifoByp,
  input  logic              fifoRst,
  input  logic              fifoHalt,
  input  logic              encBypass,
  input  logic              byteSel,
  input  logic              fillSel,
  output logic              serOut,
  output logic              charTick
);
  strobe_t strobe;

  txp_ctrl ctrl_i (
    .clk(clk), .rst(rst), .txEn(txEn), .fifoByp(fifoByp),
    .fifoRst(fifoRst), .fifoHalt(fifoHalt), .encBypass(encBypass),
    .byteSel(byteSel), .strobe(strobe), .charTick(charTick)
  );

  txp_dpath dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe), .txData(txData), .txCmd(txCmd),
    .txSpecial(txSpecial), .encBypass(encBypass), .byteSel(byteSel),
    .fillSel(fillSel), .serOut(serOut)
  );
endmodule

// File: rtl/txp_serial_tx_chk.sv
module txp_serial_tx_chk
  import txp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              charTick,
  input logic              serOut,
  input logic              txEn,
  input logic [DATA_W-1:0] txData,
  input logic              encBypass,
  input logic              byteSel,
  input logic              fifoByp,
  input logic              fifoRst,
  input logic              fifoHalt,
  input logic              fillSel
);
  logic [CNT_W-1:0] gapCnt;
  logic [CNT_W-1:0] expLast;
  logic             haveTick;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt   <= '0;
      expLast  <= '0;
      haveTick <= 1'b0;
    end else if (charTick) begin
      gapCnt   <= '0;
      expLast  <= (encBypass && !byteSel) ? CNT_W'(CHAR_LONG - 1)
                                          : CNT_W'(CHAR_SHORT - 1);
      haveTick <= 1'b1;
    end else begin
      gapCnt   <= gapCnt + 1'b1;
    end
  end

  // R1
  tick_period_chk: assert property (@(posedge clk) disable iff (rst)
    (charTick && haveTick) |-> (gapCnt == expLast));

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    charTick |=> !charTick);

  // R6
  fill_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (charTick && !txEn) |=> (serOut == $past(fillSel)));

  // R7 R9
  preenc_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (charTick && txEn && encBypass && !fifoByp) |=> (serOut == $past(txData[0])));

  // R10
  fifo_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (charTick && fifoByp && (fifoRst || fifoHalt)) |=> (serOut == $past(fillSel)));
endmodule

bind txp_serial_tx txp_serial_tx_chk chk_i (
  .clk(clk), .rst(rst), .charTick(charTick), .serOut(serOut), .txEn(txEn),
  .txData(txData), .encBypass(encBypass), .byteSel(byteSel),
  .fifoByp(fifoByp), .fifoRst(fifoRst), .fifoHalt(fifoHalt), .fillSel(fillSel)
);

// File: tb/txp_serial_tx_tb_top.sv
module txp_serial_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] txData = '0;
  logic [3:0] txCmd = '0;
  logic       txSpecial = 1'b0;
  logic       txEn = 1'b0;
  logic       fifoByp = 1'b0;
  logic       fifoRst = 1'b0;
  logic       fifoHalt = 1'b0;
  logic       encBypass = 1'b0;
  logic       byteSel = 1'b1;
  logic       fillSel = 1'b0;
  logic       serOut;
  logic       charTick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  txp_serial_tx dut_i (
    .clk(clk), .rst(rst), .txData(txData), .txCmd(txCmd), .txSpecial(txSpecial),
    .txEn(txEn), .fifoByp(fifoByp), .fifoRst(fifoRst), .fifoHalt(fifoHalt),
    .encBypass(encBypass), .byteSel(byteSel), .fillSel(fillSel),
    .serOut(serOut), .charTick(charTick)
  );

  function automatic logic [4:0] sym(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  function automatic logic [11:0] expWord();
    if (!txEn || (fifoByp && (fifoRst || fifoHalt)))
      return fillSel ? {2'b00, 5'b01101, 5'b00111} : {2'b00, 5'b10001, 5'b11000};
    if (encBypass)
      return byteSel ? {2'b00, txData} : {txCmd[1:0], txData};
    if (txSpecial)
      return {2'b00, sym(txCmd), 5'b00100};
    return {2'b00, sym(txData[7:4]), sym(txData[3:0])};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge where charTick is high; inputs already set.
  task automatic runChar(input string req);
    int len = (encBypass && !byteSel) ? 12 : 10;
    logic [11:0] exp = expWord();
    logic [11:0] got = '0;
    bit tickOk = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      got[k] = serOut;
      if (charTick != (k == len - 1)) tickOk = 1'b0;
    end
    check(got == exp, req, got, exp);
    check(tickOk, "R1 slot tick", 0, 1);
  endtask

  task automatic setIn(input bit en, input bit spec, input logic [9:0] d, input logic [3:0] c);
    txEn = en; txSpecial = spec; txData = d; txCmd = c;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 reset state
    check(serOut == 1'b0 && charTick == 1'b1, "R2 reset", {serOut, charTick}, 1);
    rst = 1'b0;
    // R2 first cycle after release (inputs sampled on the next edge)
    check(serOut == 1'b0 && charTick == 1'b1, "R2 release", {serOut, charTick}, 1);

    // R6 fill pairs after reset, both choices
    setIn(0, 0, 10'h3FF, 4'hF); fillSel = 0; runChar("R6 JK fill");
    fillSel = 1; runChar("R6 LM fill");
    fillSel = 0;

    // R4 R3 every data byte, encoded
    for (int d = 0; d < 256; d++) begin
      setIn(1, 0, 10'(d) | 10'h300, 4'(d)); runChar("R4 R3 encoded data");
    end

    // R5 every command nibble; data must not matter
    for (int c = 0; c < 16; c++) begin
      setIn(1, 1, 10'(c * 37), 4'(c)); runChar("R5 special");
      setIn(1, 1, ~10'(c * 37), 4'(c)); runChar("R5 special data ignored");
    end

    // R7 every 10-bit pre-encoded value, special select toggling
    encBypass = 1; byteSel = 1;
    for (int d = 0; d < 1024; d++) begin
      setIn(1, d[0], 10'(d), 4'(d >> 2)); runChar("R7 R3 preencoded 10-bit");
    end

    // R8 12-bit pre-encoded
    byteSel = 0;
    for (int c = 0; c < 4; c++)
      for (int d = 0; d < 64; d++) begin
        setIn(1, d[1], 10'(d * 17 + c), 4'(c) | 4'hC); runChar("R8 R1 preencoded 12-bit");
      end

    // R11 fill in a 12-bit slot, both choices
    setIn(0, 0, 10'h155, 4'hF); fillSel = 0; runChar("R11 JK fill 12-bit");
    fillSel = 1; runChar("R11 LM fill 12-bit");

    // R9 R10 FIFO stub straps, encoded and pre-encoded
    for (int m = 0; m < 2; m++) begin
      encBypass = m[0]; byteSel = 1;
      for (int s = 0; s < 16; s++) begin
        fifoByp = s[0]; fifoRst = s[1]; fifoHalt = s[2]; fillSel = s[3];
        setIn(1, 0, 10'(s * 29 + 5), 4'(s));
        runChar(fifoByp ? "R10 fifo mask" : "R9 fifo ignored");
      end
    end
    fifoByp = 0; fifoRst = 0; fifoHalt = 0;

    // R1 back-to-back width switching
    for (int i = 0; i < 8; i++) begin
      encBypass = 1; byteSel = i[0];
      setIn(1, 0, 10'(i * 91), 4'(i)); runChar("R1 width switch");
      encBypass = 0;
      setIn(1, 0, 10'(i * 13), 4'(i)); runChar("R4 after switch");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule